// File: doc/BRIEF.md
# Free-Running-Clock Serial Master

This block is the master side of a full-duplex synchronous serial link that trades fixed-length 26-bit frames with one external device. It drives a serial clock, a frame-select strobe and a serial data output, and it samples a serial data input. The serial clock keeps toggling between frames, so the external device can use it as its own clock. A frame sends one command word and, in the same frame, receives one result word.

A command source offers words through a valid/ready handshake. A frame starts at a rising serial clock edge once transmissions are allowed, a word is offered and the programmed idle gap since the last frame has elapsed. Received words leave as a one-cycle valid pulse. A frame can be cut short by an abort input or by leaving the transmit mode. A clock-only mode keeps the serial clock running while no frame may start. This suits the period when the external device is held in reset.

Top module: `fck_serial_master`

## Requirements
- R1: `mode_i` selects the operating mode. With bit 1 low (2'b00 or 2'b01), `sck_o` and `sel_o` are held low and no word is accepted. With 2'b10, `sck_o` runs but `tx_ready_o` stays low and no frame starts. With 2'b11, both the clock and frames are enabled. After reset all outputs are low.
- R2: The `sck_o` period is N system cycles, where N is `div_i` clamped to the range 2 to 17. The high phase lasts ceil(N/2) cycles and the low phase lasts floor(N/2) cycles.
- R3: A change of `div_i` takes effect at the next phase boundary. No phase is shorter than one system cycle and none is longer than ceil(17/2) cycles.
- R4: `tx_ready_o` is high only in the system cycle just before a rising `sck_o` edge. It also requires the link to be idle, the mode to be 2'b11, the gap to be met and `abort_i` to be low. A word transfers when `tx_valid_i` and `tx_ready_o` are both high.
- R5: `sel_o` rises on the same system edge as the `sck_o` rise that starts the frame. It stays high for exactly 26 serial periods and falls on a rising `sck_o` edge.
- R6: `sdo_o` carries the accepted word MSB first (bit 25 first). It changes only on rising `sck_o` edges and is low while idle.
- R7: `sdi_i` is sampled on each falling `sck_o` edge during a frame, MSB first. On the 26th falling edge the complete word appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse. `rx_data_o` then holds until the next completed frame.
- R8: After `sel_o` falls, the next frame cannot start before the (`gap_i`+1)th rising `sck_o` edge. This gives at least (`gap_i`+1) serial periods with `sel_o` low.
- R9: If `abort_i` is high during a frame, `sel_o` falls at the next rising `sck_o` edge and no received word is delivered.
- R10: Switching the mode to 2'b10 mid-frame aborts the frame in the same way. Switching bit 1 low drops `sel_o` on the next system edge. Neither case delivers a word.
- R11: `abort_i` asserted while idle only withholds `tx_ready_o`. It leaves no effect on later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (see R1) |
| div_i | input | 5 | Serial clock divide ratio, clamped to 2..17 |
| gap_i | input | 4 | Minimum idle serial periods between frames, minus one |
| abort_i | input | 1 | Abort the frame in progress |
| tx_data_i | input | 26 | Command word offered by the source |
| tx_valid_i | input | 1 | Command word valid |
| tx_ready_o | output | 1 | Command word accepted this cycle when valid |
| rx_data_o | output | 26 | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse for a new received word |
| sck_o | output | 1 | Free-running serial clock |
| sel_o | output | 1 | Frame select, active high |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |

## Verification
`tx_ready_o` is combinational and valid in the same cycle as its inputs. `sck_o`, `sel_o` and `sdo_o` change on the system edge right after their strobe cycle. `rx_valid_o` appears on the edge that produces the 26th falling serial edge. Once reset is released, the synchronizer adds two idle edges before the first of these. The bench drives inputs on the falling system edge and samples every output a quarter period later. Each sample is compared against a behavioural model that steps on the same rising edges. Period, duty, gap and select-width measurements are counted in whole system cycles from those same samples.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_TAIL  = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_CLK_ONLY = 2'b10;
  localparam logic [1:0] MODE_RUN      = 2'b11;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
  localparam logic [DIV_W-1:0] LO_LIM = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI_LIM = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] n_eff, hi_len, lo_len, cnt_q, cnt_d;
  logic             sck_d;

  always_comb begin
    if (ratio_i < LO_LIM)      n_eff = LO_LIM;
    else if (ratio_i > HI_LIM) n_eff = HI_LIM;
    else                       n_eff = ratio_i;
    lo_len = n_eff >> 1;
    hi_len = lo_len + {{(DIV_W-1){1'b0}}, n_eff[0]};
  end

  // The strobe marks the cycle whose closing edge toggles sck
  assign rise_o = run_i & ~sck_o & (cnt_q == '0);
  assign fall_o = run_i &  sck_o & (cnt_q == '0);

  always_comb begin
    sck_d = sck_o;
    cnt_d = cnt_q;
    if (!run_i) begin
      sck_d = 1'b0;
      cnt_d = '0;
    end else if (rise_o) begin
      sck_d = 1'b1;
      cnt_d = hi_len - ONE;
    end else if (fall_o) begin
      sck_d = 1'b0;
      cnt_d = lo_len - ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_o <= 1'b0;
      cnt_q <= '0;
    end else begin
      sck_o <= sck_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fsl_pkg::*;
#(
  parameter int FRAME_W = 26,
  parameter int GAP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             abort_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             sel_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             cap_o,
  output logic             deliver_o,
  output logic             clear_o
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  seq_state_e       st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [GAP_W-1:0] idle_q, idle_d;
  logic             pend_q, pend_d, sel_d;
  logic             run, full, kill, pend_now, accept;

  assign run        = mode_i[1];
  assign full       = (mode_i == MODE_RUN);
  assign kill       = abort_i | ~full;
  assign pend_now   = pend_q | ((st_q != SEQ_IDLE) & kill);
  assign tx_ready_o = rise_i & (st_q == SEQ_IDLE) & full & (idle_q >= gap_i) & ~abort_i;
  assign accept     = tx_ready_o & tx_valid_i;

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    idle_d    = idle_q;
    pend_d    = pend_now;
    sel_d     = sel_o;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    cap_o     = 1'b0;
    deliver_o = 1'b0;
    clear_o   = 1'b0;
    if (!run) begin
      st_d    = SEQ_IDLE;
      sel_d   = 1'b0;
      pend_d  = 1'b0;
      clear_o = 1'b1;
    end else if (rise_i) begin
      if (st_q == SEQ_IDLE) begin
        if (accept) begin
          st_d   = SEQ_SHIFT;
          sel_d  = 1'b1;
          bit_d  = '0;
          load_o = 1'b1;
        end else if (idle_q != '1) begin
          idle_d = idle_q + GAP_W'(1);
        end
      end else if ((st_q == SEQ_TAIL) || pend_now) begin
        st_d    = SEQ_IDLE;
        sel_d   = 1'b0;
        idle_d  = '0;
        pend_d  = 1'b0;
        clear_o = 1'b1;
      end else begin
        shift_o = 1'b1;
      end
    end else if (fall_i && (st_q == SEQ_SHIFT)) begin
      cap_o = 1'b1;
      if (bit_q == LAST_BIT) begin
        st_d      = SEQ_TAIL;
        deliver_o = ~pend_now;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      bit_q  <= '0;
      idle_q <= '0;
      pend_q <= 1'b0;
      sel_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      idle_q <= idle_d;
      pend_q <= pend_d;
      sel_o  <= sel_d;
    end
  end
endmodule

// File: rtl/shift_path.sv
module shift_path #(
  parameter int FRAME_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic               cap_i,
  input  logic               deliver_i,
  input  logic               clear_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o
);
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d;

  assign rx_d  = {rx_q[FRAME_W-2:0], sdi_i};
  assign sdo_o = tx_q[FRAME_W-1];

  always_comb begin
    tx_d = tx_q;
    if (clear_i)      tx_d = '0;
    else if (load_i)  tx_d = tx_data_i;
    else if (shift_i) tx_d = tx_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_q       <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      tx_q       <= tx_d;
      rx_valid_o <= deliver_i;
      if (cap_i)     rx_q      <= rx_d;
      if (deliver_i) rx_data_o <= rx_d;
    end
  end
endmodule

// File: rtl/fck_serial_master.sv
module fck_serial_master #(
  parameter int FRAME_W = 26,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 17,
  parameter int GAP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [GAP_W-1:0]   gap_i,
  input  logic               abort_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               sck_o,
  output logic               sel_o,
  output logic               sdo_o,
  input  logic               sdi_i
);
  logic [1:0] rs_q;
  logic       rst_core_n;
  logic       rise, fall, load, shift, cap, deliver, clear;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  sclk_divider #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
    .clk(clk), .rst_n(rst_core_n), .run_i(mode_i[1]), .ratio_i(div_i),
    .sck_o(sck_o), .rise_o(rise), .fall_o(fall)
  );

  frame_seq #(.FRAME_W(FRAME_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .mode_i(mode_i), .gap_i(gap_i),
    .abort_i(abort_i), .rise_i(rise), .fall_i(fall), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .sel_o(sel_o), .load_o(load), .shift_o(shift),
    .cap_o(cap), .deliver_o(deliver), .clear_o(clear)
  );

  shift_path #(.FRAME_W(FRAME_W)) u_path (
    .clk(clk), .rst_n(rst_core_n), .load_i(load), .shift_i(shift),
    .cap_i(cap), .deliver_i(deliver), .clear_i(clear), .tx_data_i(tx_data_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );
endmodule

// File: rtl/fck_serial_master_chk.sv
module fck_serial_master_chk #(
  parameter int DIV_MAX = 17
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       abort_i,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic       sck_o,
  input logic       sel_o,
  input logic       sdo_o
);
  localparam int HMAX = (DIV_MAX + 1) / 2;
  logic [7:0] ph_q;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= sck_o;
      if (!mode_i[1])          ph_q <= '0;
      else if (sck_o != prev_q) ph_q <= 8'd1;
      else if (ph_q != 8'hff)   ph_q <= ph_q + 8'd1;
    end
  end

  a_r1_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[1] |=> (!sck_o && !sel_o));
  a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b11) |-> !tx_ready_o);
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> (ph_q <= 8'(HMAX)));
  a_r4_ready_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> $rose(sck_o));
  a_r4_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !sel_o);
  a_r5_sel_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> $rose(sck_o));
  a_r5_sel_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_o) && $past(mode_i[1])) |-> $rose(sck_o));
  a_r6_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> ($rose(sck_o) || $fell(sel_o)));
  a_r7_rx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $fell(sck_o));
  a_r7_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  a_r9_abort_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !rx_valid_o);
  a_r10_mode_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b11) |=> !rx_valid_o);
endmodule

bind fck_serial_master fck_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .abort_i(abort_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .sck_o(sck_o),
  .sel_o(sel_o), .sdo_o(sdo_o)
);

// File: tb/fck_serial_master_test.sv
module fck_serial_master_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [4:0]  div_i = 5'd4;
  logic [3:0]  gap_i = 4'd0;
  logic        abort_i = 1'b0;
  logic [25:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        tx_ready_o, rx_valid_o, sck_o, sel_o, sdo_o;
  logic [25:0] rx_data_o;

  always #(CLK_P/2) clk = ~clk;

  fck_serial_master uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .div_i(div_i), .gap_i(gap_i),
    .abort_i(abort_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .sck_o(sck_o), .sel_o(sel_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_sync, m_left, m_st, m_idle, m_bits;
  bit m_sck, m_sel, m_pend, m_rxv;
  logic [25:0] m_out, m_in, m_rxd;

  function automatic int eff_div();
    if (div_i < 2) return 2;
    if (div_i > 17) return 17;
    return int'(div_i);
  endfunction

  function automatic bit m_rise();
    return (m_sync == 2) && mode_i[1] && !m_sck && (m_left == 0);
  endfunction

  function automatic bit m_ready();
    return m_rise() && (m_st == 0) && (mode_i == 2'b11) && (m_idle >= int'(gap_i)) && !abort_i;
  endfunction

  task automatic model_step();
    bit rise, fall, rdy, pend, cond;
    int n;
    n    = eff_div();
    rise = m_rise();
    fall = mode_i[1] && m_sck && (m_left == 0);
    rdy  = m_ready();
    cond = abort_i || (mode_i != 2'b11);
    m_rxv = 0;
    if (!mode_i[1]) begin
      m_sck = 0; m_left = 0; m_st = 0; m_sel = 0; m_out = '0; m_pend = 0;
    end else begin
      pend = m_pend || (m_st != 0 && cond);
      m_pend = pend;
      if (rise) begin
        m_sck = 1; m_left = (n + 1) / 2 - 1;
        if (m_st == 0) begin
          if (rdy && tx_valid_i) begin
            m_st = 1; m_sel = 1; m_out = tx_data_i; m_bits = 0;
          end else if (m_idle < 15) m_idle++;
        end else if (m_st == 2 || pend) begin
          m_st = 0; m_sel = 0; m_out = '0; m_idle = 0; m_pend = 0;
        end else m_out = m_out << 1;
      end else if (fall) begin
        m_sck = 0; m_left = n / 2 - 1;
        if (m_st == 1) begin
          m_in = {m_in[24:0], sdi_i};
          if (m_bits == 25) begin
            m_st = 2;
            if (!pend) begin m_rxv = 1; m_rxd = m_in; end
          end else m_bits++;
        end
      end else m_left--;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_sck = 0; m_left = 0; m_st = 0; m_sel = 0; m_out = '0;
      m_in = '0; m_idle = 0; m_pend = 0; m_rxv = 0; m_rxd = '0; m_bits = 0;
    end else if (m_sync < 2) m_sync++;
    else model_step();
  end

  // Slave device: presents its word MSB first after each rising sck in a frame
  logic [25:0] slave_word = '0;
  int  s_idx = 25;
  bit  s_prev = 0;
  always @(negedge clk) begin
    if (!sel_o) s_idx = 25;
    else if (sck_o && !s_prev) begin
      sdi_i <= slave_word[s_idx];
      if (s_idx > 0) s_idx--;
    end
    s_prev = sck_o;
  end

  // Per-cycle comparison and port measurements
  int cyc = 0, t_rise = -1, period = 0, hi_len = 0;
  int t_selr = -1, t_self = -1, sel_hi = 0, sel_lo = 0;
  int n_sel_rise = 0, n_rxv = 0, n_xfer = 0, n_ready = 0, cap_n = 0;
  bit pm_sck = 0, pm_sel = 0;
  logic [25:0] cap_w = '0, last_cap = '0, last_rx = '0, xfer_word = '0;

  always begin
    @(negedge clk);
    #(CLK_P/4);
    cyc++;
    chk(sck_o == m_sck, "R3 sck cycle", sck_o, m_sck);
    chk(sel_o == m_sel, "R5 sel cycle", sel_o, m_sel);
    chk(sdo_o == m_out[25], "R6 sdo cycle", sdo_o, m_out[25]);
    chk(tx_ready_o == m_ready(), "R4 ready cycle", tx_ready_o, m_ready());
    chk(rx_valid_o == m_rxv, "R7 rx_valid cycle", rx_valid_o, m_rxv);
    chk(rx_data_o == m_rxd, "R7 rx_data cycle", rx_data_o, m_rxd);
    if (tx_valid_i && tx_ready_o) begin n_xfer++; xfer_word = tx_data_i; end
    if (tx_ready_o) n_ready++;
    if (sck_o && !pm_sck) begin
      if (t_rise >= 0) period = cyc - t_rise;
      t_rise = cyc;
    end
    if (!sck_o && pm_sck) hi_len = cyc - t_rise;
    if (sel_o && !pm_sel) begin
      n_sel_rise++;
      if (t_self >= 0) sel_lo = cyc - t_self;
      t_selr = cyc; cap_n = 0;
    end
    if (!sel_o && pm_sel) begin sel_hi = cyc - t_selr; t_self = cyc; end
    if (sel_o && sck_o && !pm_sck) begin
      cap_w = {cap_w[24:0], sdo_o}; cap_n++;
      if (cap_n == 26) last_cap = cap_w;
    end
    if (rx_valid_o) begin n_rxv++; last_rx = rx_data_o; end
    pm_sck = sck_o; pm_sel = sel_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_one(input logic [25:0] w);
    int base;
    base = n_xfer;
    tx_data_i = w; tx_valid_i = 1'b1;
    for (int i = 0; i < 3000 && n_xfer == base; i++) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic wait_sel_low();
    for (int i = 0; i < 3000 && sel_o; i++) @(negedge clk);
    tick(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int rx0, sel0;
    tick(3);
    chk(sck_o == 0 && sel_o == 0 && tx_ready_o == 0 && rx_valid_o == 0, "R1 reset outputs", {sck_o, sel_o}, 0);
    rst_n = 1'b1;
    tick(6);
    chk(sck_o == 0, "R1 mode 00 clock low", sck_o, 0);

    // Clock-only mode: clock runs, no frames
    mode_i = 2'b10; div_i = 5'd5; tx_data_i = 26'h0ABCDEF; tx_valid_i = 1'b1;
    tick(120);
    chk(n_sel_rise == 0, "R1 no frame in clock-only", n_sel_rise, 0);
    chk(n_ready == 0, "R1 no ready in clock-only", n_ready, 0);
    chk(period == 5, "R2 period 5", period, 5);
    chk(hi_len == 3, "R2 high 3 of 5", hi_len, 3);
    tx_valid_i = 1'b0;
    div_i = 5'd2;  tick(30);
    chk(period == 2 && hi_len == 1, "R2 ratio 2", period, 2);
    div_i = 5'd17; tick(80);
    chk(period == 17, "R2 period 17", period, 17);
    chk(hi_len == 9, "R2 high 9 of 17", hi_len, 9);
    div_i = 5'd0;  tick(60);
    chk(period == 2, "R2 clamp low", period, 2);
    div_i = 5'd31; tick(80);
    chk(period == 17, "R2 clamp high", period, 17);
    div_i = 5'd3; tick(20);
    div_i = 5'd8; tick(30);
    chk(period == 8 && hi_len == 4, "R3 reload to 8", period, 8);

    // Full frames
    div_i = 5'd4; gap_i = 4'd0; mode_i = 2'b11;
    slave_word = 26'h25AC3F1;
    rx0 = n_rxv; sel0 = n_sel_rise;
    start_one(26'h1F0E3A5);
    wait_sel_low();
    chk(n_rxv == rx0 + 1, "R7 one word received", n_rxv, rx0 + 1);
    chk(last_rx == 26'h25AC3F1, "R7 received word", last_rx, 26'h25AC3F1);
    chk(last_cap == 26'h1F0E3A5, "R6 sent word", last_cap, 26'h1F0E3A5);
    chk(sel_hi == 104, "R5 select width", sel_hi, 104);
    chk(n_sel_rise - sel0 == 1, "R4 one frame per transfer", n_sel_rise - sel0, 1);

    // Minimum gap between frames
    gap_i = 4'd3; slave_word = 26'h3000001;
    sel0 = n_sel_rise;
    tx_data_i = 26'h2222222; tx_valid_i = 1'b1;
    for (int i = 0; i < 3000 && n_sel_rise < sel0 + 2; i++) @(negedge clk);
    tx_valid_i = 1'b0;
    chk(sel_lo == 16, "R8 gap of 4 periods", sel_lo, 16);
    wait_sel_low();
    chk(last_rx == 26'h3000001, "R7 word after gap", last_rx, 26'h3000001);
    chk(last_cap == 26'h2222222, "R6 word after gap", last_cap, 26'h2222222);
    gap_i = 4'd0;

    // Abort input mid-frame
    rx0 = n_rxv;
    start_one(26'h1555555);
    tick(30);
    abort_i = 1'b1; tick(1); abort_i = 1'b0;
    tick(20);
    chk(sel_o == 0, "R9 select dropped", sel_o, 0);
    chk(n_rxv == rx0, "R9 no word after abort", n_rxv, rx0);
    chk(sel_hi < 104, "R9 frame shortened", sel_hi, 104);

    // Mode change mid-frame
    start_one(26'h0333333);
    tick(30);
    mode_i = 2'b10; tick(20);
    chk(sel_o == 0 && n_rxv == rx0, "R10 clock-only aborts", n_rxv, rx0);
    mode_i = 2'b11;
    start_one(26'h0444444);
    tick(30);
    mode_i = 2'b00; tick(1);
    chk(sel_o == 0 && sck_o == 0, "R10 disable drops select", sel_o, 0);
    tick(10);
    chk(n_rxv == rx0, "R10 no word after disable", n_rxv, rx0);
    mode_i = 2'b11; tick(10);

    // Abort while idle
    sel0 = n_sel_rise;
    abort_i = 1'b1; tick(12); abort_i = 1'b0;
    chk(sel_o == 0 && n_sel_rise == sel0, "R11 idle abort starts nothing", n_sel_rise, sel0);
    slave_word = 26'h0F0F0F0;
    start_one(26'h30C30C3);
    wait_sel_low();
    chk(last_rx == 26'h0F0F0F0, "R11 next frame intact", last_rx, 26'h0F0F0F0);
    chk(last_cap == 26'h30C30C3, "R11 next word sent", last_cap, 26'h30C30C3);
    tick(10);
    finish_run();
  end
endmodule